// File: doc/BRIEF.md
# Three-Instruction Stored-Program Processor

This block is a very small processor core. It runs programs held in binary form in one word-addressed memory that stores both instructions and data. A control sequencer steps each instruction through a fetch phase, a decode phase and an execute phase, and then returns to fetch. The datapath holds an instruction pointer, sixteen 16-bit general-purpose registers and a 16-bit adder. The memory is read synchronously, one cycle after the address is presented. As a result, fetch takes two cycles and an instruction that reads a data word needs one extra cycle to finish.

A program is written into the memory through a write-only load port, normally while reset is held. When reset is released, execution starts at address 0. The core supports three operations: add two registers, copy a memory word into a register, and jump to an absolute address when a register is positive. A stop opcode, or any opcode the core does not recognise, raises the halt flag. Any register can be observed at any time through a combinational debug read port.

Top module: `fde_cpu`

## Requirements
- R1: The sequencer always runs fetch, fetch-wait, decode and execute in that order and then returns to fetch. From the first active edge after reset takes effect, an add, a jump or a stop instruction takes exactly 4 clock cycles.
- R2: Fetch reads the 32-bit word at the instruction pointer and adds 1 to the pointer. Programs therefore run from address 0 in sequence. The opcode is in bits [31:28], the register fields are in [27:24], [23:20] and [19:16], and the address is in [15:0].
- R3: Opcode 0 (add) writes the sum of the registers named in [27:24] and [23:20] into the register named in [19:16]. The sum wraps modulo 2^16 and any carry is discarded. A destination may also be one of the sources.
- R4: Opcode 1 (load) copies the low 16 bits of the memory word at address [15:0] into the register named in [27:24]. It takes 5 cycles.
- R5: Opcode 2 (jump) loads address [15:0] into the instruction pointer when the register named in [27:24] is greater than zero as a signed two's-complement value.
- R6: A jump whose tested register is zero or negative does nothing, and the instruction that follows it runs next.
- R7: Opcode 3 (stop), and any opcode from 4 to 15, sets `halt` at the end of its execute cycle. After that the core is frozen until reset: `halt` stays high and no register changes.
- R8: While `rst_n` is low, all registers read 0 and `halt` is low. The reset release is synchronised over 2 clock edges. The core then starts fetching from address 0.
- R9: `dbg_val` shows the register selected by `dbg_sel` combinationally, in every state and without disturbing execution.
- R10: A clock edge with `ld_en` high writes `ld_data` into memory word `ld_addr`. Memory contents survive reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ld_en | input | 1 | Memory load strobe |
| ld_addr | input | 8 | Memory load word address |
| ld_data | input | 32 | Memory load word |
| dbg_sel | input | 4 | Register index for debug read |
| dbg_val | output | 16 | Contents of the selected register |
| halt | output | 1 | Core has stopped |

## Verification
Each directed program has a total latency that can be counted in advance. There are 2 edges of reset synchronisation, 4 cycles for each add, jump or stop, and 5 for each load. The bench samples `halt` one edge before that total and again on the final edge, at the falling clock edge in both cases. This way any extra or missing cycle in the sequencer, or a wrongly taken branch, shows up as a timing mismatch. Register results are read through the debug port once the core has halted, and again after further idle cycles to confirm the core stays frozen.

// File: rtl/fde_pkg.sv
package fde_pkg;
  typedef enum logic [2:0] {
    PH_FETCH  = 3'd0,
    PH_FWAIT  = 3'd1,
    PH_DECODE = 3'd2,
    PH_EXEC   = 3'd3,
    PH_LWAIT  = 3'd4,
    PH_HALT   = 3'd5
  } phase_t;

  localparam logic [3:0] OP_ADD  = 4'd0;
  localparam logic [3:0] OP_LOAD = 4'd1;
  localparam logic [3:0] OP_JUMP = 4'd2;
  localparam logic [3:0] OP_STOP = 4'd3;

  localparam int IW = 32;
  localparam int FW = 4;
  localparam int AW = 16;
endpackage

// File: rtl/fde_seq.sv
module fde_seq
  import fde_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] opcode,
  output phase_t     phase
);
  phase_t phase_d;

  always_comb begin
    phase_d = phase;
    unique case (phase)
      PH_FETCH:  phase_d = PH_FWAIT;
      PH_FWAIT:  phase_d = PH_DECODE;
      PH_DECODE: phase_d = PH_EXEC;
      PH_EXEC: begin
        if (opcode == OP_ADD || opcode == OP_JUMP) phase_d = PH_FETCH;
        else if (opcode == OP_LOAD)                phase_d = PH_LWAIT;
        else                                       phase_d = PH_HALT;
      end
      PH_LWAIT:  phase_d = PH_FETCH;
      PH_HALT:   phase_d = PH_HALT;
      default:   phase_d = PH_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_FETCH;
    else        phase <= phase_d;
  end
endmodule

// File: rtl/fde_regfile.sv
module fde_regfile #(
  parameter int DW   = 16,
  parameter int NREG = 16,
  localparam int RAW = $clog2(NREG)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic [RAW-1:0] waddr,
  input  logic [DW-1:0]  wdata,
  input  logic [RAW-1:0] ra,
  input  logic [RAW-1:0] rb,
  input  logic [RAW-1:0] rdbg,
  output logic [DW-1:0]  qa,
  output logic [DW-1:0]  qb,
  output logic [DW-1:0]  qdbg
);
  logic [DW-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic wen;
    assign wen = we && (waddr == RAW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   regs[g] <= '0;
      else if (wen) regs[g] <= wdata;
    end
  end

  assign qa   = regs[ra];
  assign qb   = regs[rb];
  assign qdbg = regs[rdbg];
endmodule

// File: rtl/fde_mem.sv
module fde_mem #(
  parameter int WW = 32,
  parameter int MAW = 8,
  localparam int DEPTH = 1 << MAW
) (
  input  logic           clk,
  input  logic           wen,
  input  logic [MAW-1:0] waddr,
  input  logic [WW-1:0]  wdata,
  input  logic [MAW-1:0] raddr,
  output logic [WW-1:0]  rdata
);
  logic [WW-1:0] words [DEPTH];

  always_ff @(posedge clk) begin
    if (wen) words[waddr] <= wdata;
    rdata <= words[raddr];
  end
endmodule

// File: rtl/fde_cpu.sv
module fde_cpu
  import fde_pkg::*;
#(
  parameter int DW  = 16,
  parameter int MAW = 8,
  localparam int NREG = 1 << FW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ld_en,
  input  logic [MAW-1:0] ld_addr,
  input  logic [IW-1:0]  ld_data,
  input  logic [FW-1:0]  dbg_sel,
  output logic [DW-1:0]  dbg_val,
  output logic           halt
);
  logic [1:0]    rst_sync;
  logic          core_rst_n;
  phase_t        phase;
  logic [AW-1:0] ip_q, ip_d;
  logic          ip_en;
  logic [IW-1:0] ir_q;
  logic          ir_en;
  logic [DW-1:0] opa_q, opb_q, qa, qb;
  logic          opnd_en;
  logic [IW-1:0] mem_rdata;
  logic [MAW-1:0] mem_raddr;
  logic          rf_we;
  logic [FW-1:0] rf_waddr;
  logic [DW-1:0] rf_wdata;
  logic [DW-1:0] sum;
  logic          jmp_taken;

  logic [3:0]    opcode;
  logic [FW-1:0] fld1, fld2, fld3;
  logic [AW-1:0] fld_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign core_rst_n = rst_sync[1];

  assign opcode   = ir_q[31:28];
  assign fld1     = ir_q[27:24];
  assign fld2     = ir_q[23:20];
  assign fld3     = ir_q[19:16];
  assign fld_addr = ir_q[15:0];

  fde_seq u_seq (
    .clk    (clk),
    .rst_n  (core_rst_n),
    .opcode (opcode),
    .phase  (phase)
  );

  assign mem_raddr = (phase == PH_EXEC) ? fld_addr[MAW-1:0] : ip_q[MAW-1:0];

  fde_mem #(.WW(IW), .MAW(MAW)) u_mem (
    .clk   (clk),
    .wen   (ld_en),
    .waddr (ld_addr),
    .wdata (ld_data),
    .raddr (mem_raddr),
    .rdata (mem_rdata)
  );

  assign sum       = opa_q + opb_q;
  assign jmp_taken = !opa_q[DW-1] && (opa_q != '0);

  always_comb begin
    rf_we    = 1'b0;
    rf_waddr = fld3;
    rf_wdata = sum;
    if (phase == PH_EXEC && opcode == OP_ADD) begin
      rf_we = 1'b1;
    end else if (phase == PH_LWAIT) begin
      rf_we    = 1'b1;
      rf_waddr = fld1;
      rf_wdata = mem_rdata[DW-1:0];
    end
  end

  fde_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk   (clk),
    .rst_n (core_rst_n),
    .we    (rf_we),
    .waddr (rf_waddr),
    .wdata (rf_wdata),
    .ra    (fld1),
    .rb    (fld2),
    .rdbg  (dbg_sel),
    .qa    (qa),
    .qb    (qb),
    .qdbg  (dbg_val)
  );

  always_comb begin
    ip_en = 1'b0;
    ip_d  = ip_q + AW'(1);
    if (phase == PH_FWAIT) begin
      ip_en = 1'b1;
    end else if (phase == PH_EXEC && opcode == OP_JUMP && jmp_taken) begin
      ip_en = 1'b1;
      ip_d  = fld_addr;
    end
  end

  assign ir_en   = (phase == PH_FWAIT);
  assign opnd_en = (phase == PH_DECODE);

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n)  ip_q <= '0;
    else if (ip_en)   ip_q <= ip_d;
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n)  ir_q <= '0;
    else if (ir_en)   ir_q <= mem_rdata;
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      opa_q <= '0;
      opb_q <= '0;
    end else if (opnd_en) begin
      opa_q <= qa;
      opb_q <= qb;
    end
  end

  assign halt = (phase == PH_HALT);
endmodule

// File: rtl/fde_cpu_chk.sv
module fde_cpu_chk
  import fde_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input phase_t        phase,
  input logic [AW-1:0] ip,
  input logic [3:0]    opcode,
  input logic [15:0]   opa,
  input logic [AW-1:0] target,
  input logic          rf_we,
  input logic          halt
);
  a_r1_fetch_to_wait: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_FETCH |=> phase == PH_FWAIT);
  a_r1_wait_to_decode: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_FWAIT |=> phase == PH_DECODE);
  a_r1_decode_to_exec: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_DECODE |=> phase == PH_EXEC);
  a_r2_ip_advance: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_FWAIT |=> ip == $past(ip) + AW'(1));
  a_r4_load_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_EXEC && opcode == OP_LOAD) |=> phase == PH_LWAIT);
  a_r5_jump_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_EXEC && opcode == OP_JUMP && $signed(opa) > 16'sd0) |=> ip == $past(target));
  a_r6_jump_skip: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_EXEC && opcode == OP_JUMP && $signed(opa) <= 16'sd0) |=> $stable(ip));
  a_r7_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> halt && $stable(ip));
  a_r7_no_write_halted: assert property (@(posedge clk) disable iff (!rst_n)
    halt |-> !rf_we);
endmodule

bind fde_cpu fde_cpu_chk u_chk (
  .clk    (clk),
  .rst_n  (core_rst_n),
  .phase  (phase),
  .ip     (ip_q),
  .opcode (opcode),
  .opa    (opa_q),
  .target (fld_addr),
  .rf_we  (rf_we),
  .halt   (halt)
);

// File: tb/fde_cpu_bench.sv
module fde_cpu_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ld_en;
  logic [7:0]  ld_addr;
  logic [31:0] ld_data;
  logic [3:0]  dbg_sel;
  logic [15:0] dbg_val;
  logic        halt;

  int tests = 0;
  int fails = 0;
  logic [31:0] img [256];

  always #2.5 clk = ~clk;

  fde_cpu u_fde_cpu (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_addr(ld_addr),
    .ld_data(ld_data), .dbg_sel(dbg_sel), .dbg_val(dbg_val), .halt(halt)
  );

  function automatic logic [31:0] enc(input logic [3:0] op, input logic [3:0] a,
                                      input logic [3:0] b, input logic [3:0] c,
                                      input logic [15:0] ad);
    return {op, a, b, c, ad};
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic reg_is(input string tag, input int idx, input logic [15:0] exp);
    @(negedge clk);
    dbg_sel = 4'(idx);
    #0.5;
    chk(tag, {16'h0, dbg_val}, {16'h0, exp});
  endtask

  task automatic clear_img();
    for (int i = 0; i < 256; i++) img[i] = enc(4'd3, 4'd0, 4'd0, 4'd0, 16'h0);
  endtask

  // Hold reset, write the image, release, then check halt one edge early and on time.
  task automatic run(input string tag, input int edges);
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      ld_en = 1'b1; ld_addr = 8'(i); ld_data = img[i];
    end
    @(negedge clk);
    ld_en = 1'b0;
    rst_n = 1'b1;
    repeat (edges - 1) @(posedge clk);
    @(negedge clk);
    chk({tag, " halt early"}, {31'h0, halt}, 32'h0);
    @(posedge clk);
    @(negedge clk);
    chk({tag, " halt due"}, {31'h0, halt}, 32'h1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #0.5;
    chk("R8 halt low in reset", {31'h0, halt}, 32'h0);
    for (int r = 0; r < 16; r++) reg_is("R8 reg cleared", r, 16'h0);
  endtask

  task automatic t_stop();
    clear_img();
    run("R1 R7 stop at 0", 6);
    repeat (10) @(posedge clk);
    @(negedge clk);
    chk("R7 halt sticky", {31'h0, halt}, 32'h1);
  endtask

  task automatic t_load();
    clear_img();
    img[0] = enc(4'd1, 4'd7, 4'd0, 4'd0, 16'h0040);
    img[8'h40] = 32'hABCD_5A5A;
    run("R4 load timing", 11);
    reg_is("R4 load low half", 7, 16'h5A5A);
    reg_is("R10 other reg untouched", 6, 16'h0);
  endtask

  task automatic t_add();
    clear_img();
    img[0] = enc(4'd1, 4'd1, 4'd0, 4'd0, 16'h0040);
    img[1] = enc(4'd1, 4'd2, 4'd0, 4'd0, 16'h0041);
    img[2] = enc(4'd0, 4'd1, 4'd2, 4'd3, 16'h0);
    img[3] = enc(4'd1, 4'd4, 4'd0, 4'd0, 16'h0042);
    img[4] = enc(4'd0, 4'd4, 4'd2, 4'd5, 16'h0);
    img[5] = enc(4'd0, 4'd4, 4'd4, 4'd4, 16'h0);
    img[8'h40] = 32'h0000_7FFF;
    img[8'h41] = 32'h0000_0001;
    img[8'h42] = 32'h0000_FFFF;
    run("R1 R2 add program timing", 33);
    reg_is("R3 sum 7FFF+1", 3, 16'h8000);
    reg_is("R3 wrap FFFF+1", 5, 16'h0000);
    reg_is("R3 dest is source", 4, 16'hFFFE);
    reg_is("R3 source kept", 1, 16'h7FFF);
  endtask

  task automatic t_jump_taken();
    clear_img();
    img[0] = enc(4'd1, 4'd1, 4'd0, 4'd0, 16'h0040);
    img[1] = enc(4'd2, 4'd1, 4'd0, 4'd0, 16'h0004);
    img[2] = enc(4'd1, 4'd5, 4'd0, 4'd0, 16'h0042);
    img[4] = enc(4'd1, 4'd6, 4'd0, 4'd0, 16'h0042);
    img[8'h40] = 32'h0000_0005;
    img[8'h42] = 32'h0000_1111;
    run("R5 taken timing", 20);
    reg_is("R5 target ran", 6, 16'h1111);
    reg_is("R5 skipped slot", 5, 16'h0);
  endtask

  task automatic t_jump_zero();
    clear_img();
    img[0] = enc(4'd2, 4'd1, 4'd0, 4'd0, 16'h0004);
    img[1] = enc(4'd1, 4'd5, 4'd0, 4'd0, 16'h0042);
    img[4] = enc(4'd1, 4'd6, 4'd0, 4'd0, 16'h0042);
    img[8'h42] = 32'h0000_1111;
    run("R6 zero timing", 15);
    reg_is("R6 zero falls through", 5, 16'h1111);
    reg_is("R6 zero no target", 6, 16'h0);
  endtask

  task automatic t_jump_neg();
    clear_img();
    img[0] = enc(4'd1, 4'd1, 4'd0, 4'd0, 16'h0040);
    img[1] = enc(4'd2, 4'd1, 4'd0, 4'd0, 16'h0005);
    img[2] = enc(4'd1, 4'd5, 4'd0, 4'd0, 16'h0042);
    img[5] = enc(4'd1, 4'd6, 4'd0, 4'd0, 16'h0042);
    img[8'h40] = 32'h0000_8000;
    img[8'h42] = 32'h0000_2222;
    run("R6 negative timing", 20);
    reg_is("R6 negative falls through", 5, 16'h2222);
    reg_is("R6 negative no target", 6, 16'h0);
  endtask

  task automatic t_bad_op();
    clear_img();
    img[0] = enc(4'd1, 4'd1, 4'd0, 4'd0, 16'h0040);
    img[1] = 32'hF000_0000;
    img[2] = enc(4'd1, 4'd2, 4'd0, 4'd0, 16'h0040);
    img[8'h40] = 32'h0000_1234;
    run("R7 unknown opcode timing", 11);
    repeat (20) @(posedge clk);
    @(negedge clk);
    chk("R7 still halted", {31'h0, halt}, 32'h1);
    reg_is("R7 frozen after bad op", 2, 16'h0);
    reg_is("R9 debug read while halted", 1, 16'h1234);
  endtask

  initial begin
    rst_n = 1'b0; ld_en = 1'b0; ld_addr = '0; ld_data = '0; dbg_sel = '0;
    repeat (3) @(posedge clk);
    t_reset();
    t_stop();
    t_load();
    t_add();
    t_jump_taken();
    t_jump_zero();
    t_jump_neg();
    t_bad_op();
    t_reset();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule